// File: doc/BRIEF.md
# Clock Reference Mode Controller

This block chooses the operating mode of a clock synchronizer inside a network element. It watches a two-bit mode request, a pulse that marks a change of the selected reference, a quality flag from a reference monitor, a bit that disables automatic recovery from holdover, and a release bit that lets software re-enable the loop by hand. From these it keeps one of five states: Reset, Free-run, Normal (locked), Manual Holdover and Auto Holdover. It drives the state code and two status flags, one for lock and one for holdover.

When the reference fails while the loop is locked, the block moves to Auto Holdover on its own. There are two ways back to Normal. In the first, the block returns as soon as the reference is good again. In the second, the block waits until software sends a full high-then-low pulse on the release bit while the reference stays good. This second way stops the loop from toggling on a reference of doubtful quality. A release pulse that begins while the reference is bad is thrown away.

Top module: `clk_mode_ctrl`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state code becomes Reset (0) and both flags are 0. State codes: Reset 0, Free-run 1, Normal 2, Manual Holdover 3, Auto Holdover 4.
- R2: At the first edge with `rst_n` high after Reset, the next state depends on `mode_sel` and `ref_ok`. Code 10 gives Free-run. Code 01 gives Manual Holdover. Code 00 gives Normal when `ref_ok` is 1, and Free-run when `ref_ok` is 0.
- R3: Outside Reset, `mode_sel` = 10 moves the machine to Free-run at the next edge from any state. This request takes priority over every other input.
- R4: In Free-run, `mode_sel` = 00 with `ref_ok` = 1 moves to Normal, and `mode_sel` = 01 moves to Manual Holdover.
- R5: In Normal, `mode_sel` = 01 or a `ref_change` pulse moves to Manual Holdover. Failing that, `mode_sel` = 00 with `ref_ok` = 0 moves to Auto Holdover.
- R6: In Manual Holdover, `mode_sel` = 00 moves to Normal when `ref_ok` is 1, and to Auto Holdover when `ref_ok` is 0.
- R7: In Auto Holdover, `mode_sel` = 01 or a `ref_change` pulse moves to Manual Holdover.
- R8: In Auto Holdover with `auto_ret_dis` = 0 and `mode_sel` = 00, the machine returns to Normal at the first edge where `ref_ok` is 1.
- R9: In Auto Holdover with `auto_ret_dis` = 1, the machine returns to Normal only at the edge where `rel_bit` is seen low again. The rising edge of that pulse must have been seen in Auto Holdover with `ref_ok` = 1, and `ref_ok` must have stayed 1 since then. While `rel_bit` is high, the machine never enters Normal.
- R10: A release pulse is discarded when its rising edge arrives while `ref_ok` is 0. It is also discarded when `ref_ok` drops before the pulse falls, or when the machine leaves Auto Holdover before the pulse falls. A discarded pulse has no effect, and a new complete pulse is needed.
- R11: `lock_o` is 1 only in Normal. `holdover_o` is 1 only in Manual Holdover and in Auto Holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; holds the machine in Reset |
| mode_sel | input | 2 | Mode request: 00 automatic, 01 holdover, 10 free-run |
| ref_change | input | 1 | One-cycle pulse when the selected reference changes |
| ref_ok | input | 1 | Reference qualified good (1) or failed (0) |
| auto_ret_dis | input | 1 | 1 makes recovery from Auto Holdover wait for a release pulse |
| rel_bit | input | 1 | Manual release bit; a full 0-1-0 pulse releases the holdover |
| state_o | output | 3 | Current state code |
| lock_o | output | 1 | High only in Normal |
| holdover_o | output | 1 | High in Manual or Auto Holdover |

## Verification
Every input takes effect at the first rising edge after it is applied. The state code changes at that edge. The two flags are decoded directly from the state register, so they change in the same cycle as the state code, and no result needs more than one clock. The release tracker registers `rel_bit`, so the rise and the fall of a pulse are seen at two different edges. The Normal state appears at the edge that samples the low level. The bench drives inputs on the falling edge and checks the state and both flags on the next falling edge. That gives one full rising edge between stimulus and check.

// File: rtl/clk_mode_pkg.sv
// Package: clk_mode_pkg
// Holds the state codes and mode-request codes that the controller and its
// checker share. The state codes appear on the state output, so software
// and the bench depend on their values.
package clk_mode_pkg;

    localparam int STATE_W = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET  = 3'd0,
        ST_FREE   = 3'd1,
        ST_NORMAL = 3'd2,
        ST_HOLD   = 3'd3,
        ST_AUTO   = 3'd4
    } mode_state_e;

    localparam logic [SEL_W-1:0] SEL_AUTO = 2'b00;
    localparam logic [SEL_W-1:0] SEL_HOLD = 2'b01;
    localparam logic [SEL_W-1:0] SEL_FREE = 2'b10;

endpackage

// File: rtl/clk_mode_rel_track.sv
// Module: clk_mode_rel_track
// Watches the manual release bit for a full 0-1-0 pulse. The pulse counts
// only if its rise is seen while the machine is in Auto Holdover with a good
// reference, and only if the reference stays good until the fall.
// Assumes rel_bit is already synchronous to clk.
module clk_mode_rel_track (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_bit,
    input  logic ref_ok,
    input  logic in_auto,
    output logic release_done
);

    logic rel_q;
    logic armed_q;
    logic rel_rise;
    logic rel_fall;
    logic armed_d;

    // Edge detection against the registered copy of the release bit.
    always_comb begin
        rel_rise = rel_bit & ~rel_q;
        rel_fall = ~rel_bit & rel_q;
    end

    // The tracker arms on a qualified rise and disarms on a fall, on a bad
    // reference, or when the machine is outside Auto Holdover.
    always_comb begin
        armed_d      = in_auto & ref_ok & (rel_rise | (armed_q & ~rel_fall));
        release_done = in_auto & ref_ok & armed_q & rel_fall;
    end

    // Registers for the delayed release bit and the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            rel_q   <= rel_bit;
            armed_q <= armed_d;
        end
    end

endmodule

// File: rtl/clk_mode_fsm.sv
// Module: clk_mode_fsm
// Holds the five-state mode machine. A free-run request has top priority.
// Reference loss in Normal moves to Auto Holdover. Recovery from Auto
// Holdover is automatic, or it waits for release_done from the tracker.
// Assumes every input is synchronous to clk. Mode code 11 holds the
// present state.
module clk_mode_fsm
    import clk_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] mode_sel,
    input  logic             ref_change,
    input  logic             ref_ok,
    input  logic             auto_ret_dis,
    input  logic             release_done,
    output mode_state_e      state
);

    mode_state_e state_d;

    // Next-state selection; the free-run request is checked first.
    always_comb begin
        state_d = state;
        if (state == ST_RESET) begin
            if (mode_sel == SEL_HOLD)
                state_d = ST_HOLD;
            else if (mode_sel == SEL_AUTO && ref_ok)
                state_d = ST_NORMAL;
            else
                state_d = ST_FREE;
        end else if (mode_sel == SEL_FREE) begin
            state_d = ST_FREE;
        end else begin
            unique case (state)
                ST_FREE: begin
                    if (mode_sel == SEL_HOLD)
                        state_d = ST_HOLD;
                    else if (mode_sel == SEL_AUTO && ref_ok)
                        state_d = ST_NORMAL;
                end
                ST_NORMAL: begin
                    if (mode_sel == SEL_HOLD || ref_change)
                        state_d = ST_HOLD;
                    else if (mode_sel == SEL_AUTO && !ref_ok)
                        state_d = ST_AUTO;
                end
                ST_HOLD: begin
                    if (mode_sel == SEL_AUTO)
                        state_d = ref_ok ? ST_NORMAL : ST_AUTO;
                end
                ST_AUTO: begin
                    if (mode_sel == SEL_HOLD || ref_change)
                        state_d = ST_HOLD;
                    else if (mode_sel == SEL_AUTO && ref_ok &&
                             (!auto_ret_dis || release_done))
                        state_d = ST_NORMAL;
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RESET;
        else
            state <= state_d;
    end

endmodule

// File: rtl/clk_mode_status.sv
// Module: clk_mode_status
// Decodes the lock and holdover flags from the state register. Both flags
// are combinational from that register, so they change in the same cycle
// as the state code.
module clk_mode_status
    import clk_mode_pkg::*;
(
    input  mode_state_e state,
    output logic        lock,
    output logic        holdover
);

    // Flag decode.
    always_comb begin
        lock     = (state == ST_NORMAL);
        holdover = (state == ST_HOLD) || (state == ST_AUTO);
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
// Module: clk_mode_ctrl
// Top of the clock reference mode controller. It ties together the state
// machine, the release-pulse tracker and the flag decode. It assumes all
// inputs are synchronous to clk, and that ref_change lasts one cycle.
module clk_mode_ctrl
    import clk_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   mode_sel,
    input  logic               ref_change,
    input  logic               ref_ok,
    input  logic               auto_ret_dis,
    input  logic               rel_bit,
    output logic [STATE_W-1:0] state_o,
    output logic               lock_o,
    output logic               holdover_o
);

    mode_state_e state;
    logic        in_auto;
    logic        release_done;

    // Tells the release tracker when the machine sits in Auto Holdover.
    always_comb in_auto = (state == ST_AUTO);

    clk_mode_rel_track u_rel (
        .clk          (clk),
        .rst_n        (rst_n),
        .rel_bit      (rel_bit),
        .ref_ok       (ref_ok),
        .in_auto      (in_auto),
        .release_done (release_done)
    );

    clk_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .ref_change   (ref_change),
        .ref_ok       (ref_ok),
        .auto_ret_dis (auto_ret_dis),
        .release_done (release_done),
        .state        (state)
    );

    clk_mode_status u_stat (
        .state    (state),
        .lock     (lock_o),
        .holdover (holdover_o)
    );

    // Drives the state code onto the output port.
    always_comb state_o = state;

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
// Module: clk_mode_ctrl_chk
// Property checker for clk_mode_ctrl, attached through bind. It reads only
// the ports of the top module.
module clk_mode_ctrl_chk
    import clk_mode_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   mode_sel,
    input logic               ref_change,
    input logic               ref_ok,
    input logic               auto_ret_dis,
    input logic               rel_bit,
    input logic [STATE_W-1:0] state_o,
    input logic               lock_o,
    input logic               holdover_o
);

    a_r3_free_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == SEL_FREE && state_o != ST_RESET) |=> (state_o == ST_FREE));

    a_r5_fail_to_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_NORMAL && mode_sel == SEL_AUTO && !ref_change && !ref_ok)
        |=> (state_o == ST_AUTO));

    a_r7_auto_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AUTO && mode_sel == SEL_HOLD) |=> (state_o == ST_HOLD));

    a_r8_auto_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AUTO && mode_sel == SEL_AUTO && !ref_change &&
         !auto_ret_dis && ref_ok) |=> (state_o == ST_NORMAL));

    a_r9_high_release_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AUTO && auto_ret_dis && rel_bit) |=> (state_o != ST_NORMAL));

    a_r10_bad_ref_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AUTO && !ref_ok) |=> (state_o != ST_NORMAL));

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_o && holdover_o));

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .ref_change   (ref_change),
    .ref_ok       (ref_ok),
    .auto_ret_dis (auto_ret_dis),
    .rel_bit      (rel_bit),
    .state_o      (state_o),
    .lock_o       (lock_o),
    .holdover_o   (holdover_o)
);

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for clk_mode_ctrl. Inputs change on the falling edge. Results are
// checked on the next falling edge, one rising edge later.
module clk_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       ref_change = 1'b0;
    logic       ref_ok = 1'b0;
    logic       auto_ret_dis = 1'b0;
    logic       rel_bit = 1'b0;
    logic [2:0] state_o;
    logic       lock_o;
    logic       holdover_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    clk_mode_ctrl u_clk_mode_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .ref_change   (ref_change),
        .ref_ok       (ref_ok),
        .auto_ret_dis (auto_ret_dis),
        .rel_bit      (rel_bit),
        .state_o      (state_o),
        .lock_o       (lock_o),
        .holdover_o   (holdover_o)
    );

    // Entry layout: {mode_sel[1:0], ref_change, ref_ok, auto_ret_dis, rel_bit, expected_state[2:0]}
    localparam int NV = 40;
    localparam logic [8:0] VEC [NV] = '{
        9'b10_0_1_0_0_001, // R2 leave reset to free-run
        9'b00_0_0_0_0_001, // R4 bad reference keeps free-run
        9'b00_0_1_0_0_010, // R4 free-run to normal
        9'b00_0_0_0_0_100, // R5 reference fails
        9'b00_0_0_0_0_100, // R8 still bad
        9'b00_0_1_0_0_010, // R8 automatic return
        9'b00_1_1_0_0_011, // R5 reference change
        9'b00_0_1_0_0_010, // R6 manual hold back to normal
        9'b01_0_1_0_0_011, // R5 holdover request
        9'b01_0_1_0_0_011, // R6 stays in holdover
        9'b00_0_0_0_0_100, // R6 hold with bad ref to auto
        9'b10_0_0_0_0_001, // R3 forced free-run
        9'b00_0_1_1_0_010, // R4
        9'b00_0_0_1_0_100, // R5
        9'b00_0_1_1_0_100, // R9 no release yet
        9'b00_0_1_1_1_100, // R9 rise
        9'b00_0_1_1_0_010, // R9 fall releases
        9'b00_0_0_1_0_100, // R5
        9'b00_0_0_1_1_100, // R10 rise with bad reference
        9'b00_0_1_1_1_100, // R10 good, still high
        9'b00_0_1_1_0_100, // R10 fall discarded
        9'b00_0_1_1_1_100, // R9 new rise
        9'b00_0_1_1_0_010, // R9 release
        9'b00_0_0_1_0_100, // R5
        9'b01_0_0_1_0_011, // R7 mode request
        9'b00_0_0_1_0_100, // R6
        9'b00_1_0_1_0_011, // R7 reference change
        9'b10_0_1_0_0_001, // R3
        9'b01_0_1_0_0_011, // R4 free-run to hold
        9'b00_0_0_1_0_100, // R6
        9'b00_0_1_1_1_100, // R9 armed
        9'b01_0_1_1_1_011, // R10 leave auto while armed
        9'b00_0_0_1_1_100, // R6
        9'b00_0_1_1_0_100, // R10 fall after leaving is discarded
        9'b00_0_1_0_0_010, // R8
        9'b00_0_0_1_0_100, // R5
        9'b00_0_1_1_1_100, // R9 armed
        9'b00_0_0_1_1_100, // R10 reference drops mid-pulse
        9'b00_0_1_1_0_100, // R10 fall discarded
        9'b10_0_0_0_0_001  // R3 from auto holdover
    };

    // Compares the state code and both flags with the values implied by the expected state (R11).
    task automatic check_state(input string req, input logic [2:0] exp);
        logic exp_lock;
        logic exp_hold;
        exp_lock = (exp == 3'd2);
        exp_hold = (exp == 3'd3) || (exp == 3'd4);
        checks++;
        if (state_o !== exp || lock_o !== exp_lock || holdover_o !== exp_hold) begin
            errors++;
            $display("FAIL %s R11: state=%0d lock=%0b hold=%0b expected state=%0d lock=%0b hold=%0b",
                     req, state_o, lock_o, holdover_o, exp, exp_lock, exp_hold);
        end
    endtask

    // Applies one set of inputs at a falling edge and checks at the next falling edge.
    task automatic step(input logic rn, input logic [1:0] m, input logic c,
                        input logic ok, input logic ad, input logic rb,
                        input string req, input logic [2:0] exp);
        rst_n = rn; mode_sel = m; ref_change = c;
        ref_ok = ok; auto_ret_dis = ad; rel_bit = rb;
        @(negedge clk);
        check_state(req, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1", 3'd0);
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3],
                 $sformatf("vector %0d", i), VEC[i][2:0]);
        end
        step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R4", 3'd2);
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R1", 3'd0);
        step(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R2", 3'd3);
        step(1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R1", 3'd0);
        step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R2", 3'd2);
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R1", 3'd0);
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R2", 3'd1);
        step(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R4", 3'd2);
        step(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R3", 3'd1);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: ends a hung run and counts it as a failed check.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule